// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master DMA engine for one storage port. Software places a table of 8-byte descriptors in system memory, presents the table location, a shared upper address for the data buffers and a direction, and then raises a start bit. The engine reads each descriptor over a single-request memory interface. It decodes the buffer address, the byte count and the final-entry flag. It then moves the buffer in 32-bit beats with byte enables. The beats go between memory and a device-side valid/ready port.

When the descriptor flagged as last has finished, the engine drops its active status and raises a sticky interrupt flag. A buffer that would run past a 64 KB region edge is refused: the engine raises a sticky error flag and stops without moving any data for that entry. If the start bit is lowered mid-transfer, the engine finishes only the memory request already outstanding and then goes idle. Each port instantiates its own engine, and instances share no state.

Top module: `sg_dma_engine`

## Requirements
- R1: During and after reset, `active`, `irq_flag`, `err_flag`, `mem_req`, `dev_tx_valid` and `dev_rx_ready` are 0.
- R2: A transfer begins on a rising edge of `start`. Each descriptor is read as two memory reads, first at the table pointer and then at the pointer plus 4. Address bits 63:32 come from `tbl_base_hi`, and bits 1:0 of `tbl_base_lo` are treated as zero.
- R3: In the descriptor's second word, bits 15:0 are the byte count, where 0 stands for 65536, and bit 31 marks the last descriptor. Bit 0 of the first word (the buffer address) is ignored.
- R4: Each data beat uses a word-aligned address, and byte-enable bit i is set exactly when byte i of that word belongs to the buffer. Beats walk the buffer upward, and each beat covers bytes up to the next word boundary.
- R5: With `to_mem`=0, each memory read beat is then offered on `dev_tx_*` with the same data and byte enables, in order.
- R6: With `to_mem`=1, each word accepted on `dev_rx_*` is written to memory as the next beat, with that beat's byte enables.
- R7: Data beat addresses take bits 63:32 from `buf_upper`, for every descriptor of the table.
- R8: After a descriptor that is not last, the next one is read at pointer plus 8. After the last descriptor completes, `active` falls in the same cycle as `irq_flag` rises.
- R9: If the buffer's low 16 address bits plus its count exceed 65536, no data beat is issued for it, `err_flag` sets, `irq_flag` stays clear, and `active` falls. A buffer that ends exactly on the region edge is legal.
- R10: If `start` is low while no memory request is pending, no memory request is issued in the next cycle. The engine returns to idle without setting any flag.
- R11: `irq_flag` and `err_flag` stay set until a one-cycle pulse on `irq_clr` or `err_clr`, respectively.
- R12: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`, and its `mem_be` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run bit: rising edge starts, low stops |
| to_mem | input | 1 | 1: device to memory, 0: memory to device |
| tbl_base_lo | input | 32 | Descriptor table pointer, bits 31:0 |
| tbl_base_hi | input | 32 | Descriptor table pointer, bits 63:32 |
| buf_upper | input | 32 | Bits 63:32 shared by all data buffers |
| irq_clr | input | 1 | Clear pulse for irq_flag |
| err_clr | input | 1 | Clear pulse for err_flag |
| active | output | 1 | Engine is walking a table |
| irq_flag | output | 1 | Sticky: table completed |
| err_flag | output | 1 | Sticky: region-crossing buffer refused |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 64 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_tx_valid | output | 1 | Beat toward the device is valid |
| dev_tx_data | output | 32 | Beat toward the device |
| dev_tx_be | output | 4 | Byte enables of that beat |
| dev_tx_ready | input | 1 | Device accepts the beat |
| dev_rx_valid | input | 1 | Beat from the device is valid |
| dev_rx_data | input | 32 | Beat from the device |
| dev_rx_ready | output | 1 | Engine accepts a device beat |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high and that `mem_rdata` is valid in that same cycle. They also assume that `to_mem` and the three address inputs stay fixed while `active` is high. In the bench, acknowledges are only given after a request has been seen, with zero to one cycles of delay. The device handshakes follow both an always-ready and an alternating pattern. All configuration changes are made while the engine is idle, and the descriptor tables are built in bench memory. Every input is driven between clock edges.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BE_W     = WORD_W / 8;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned DESC_LEN = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_LO,
    S_FETCH_HI,
    S_MEM,
    S_DEV,
    S_NEXT,
    S_DONE,
    S_ERROR
  } sg_state_e;
endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 32
) (
  input  logic [AW-1:0] word0,
  input  logic [31:0]   word1,
  output logic [AW-1:0] buf_addr,
  output logic [CNT_W:0] byte_cnt,
  output logic          last,
  output logic          cross_err
);
  localparam logic [CNT_W:0] REGION = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W+1:0] end_sum;
  logic             unused_bits;

  assign buf_addr    = {word0[AW-1:1], 1'b0};
  assign byte_cnt    = (word1[CNT_W-1:0] == '0) ? REGION : {1'b0, word1[CNT_W-1:0]};
  assign last        = word1[31];
  assign end_sum     = (CNT_W+2)'(buf_addr[CNT_W-1:0]) + (CNT_W+2)'(byte_cnt);
  assign cross_err   = end_sum > (CNT_W+2)'(REGION);
  assign unused_bits = ^word1[30:CNT_W];
endmodule

// File: rtl/sg_beat_lanes.sv
module sg_beat_lanes #(
  parameter int unsigned BE_W  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic [$clog2(BE_W)-1:0] off,
  input  logic [CNT_W:0]          remaining,
  output logic [BE_W-1:0]         be,
  output logic [$clog2(BE_W):0]   nbytes
);
  localparam int unsigned OFF_W = $clog2(BE_W);
  localparam int unsigned NB_W  = OFF_W + 1;

  logic [NB_W-1:0] span;
  logic [NB_W:0]   lo_lane;
  logic [NB_W:0]   hi_lane;

  assign span    = NB_W'(BE_W) - NB_W'(off);
  assign nbytes  = (remaining < (CNT_W+1)'(span)) ? remaining[NB_W-1:0] : span;
  assign lo_lane = (NB_W+1)'(off);
  assign hi_lane = (NB_W+1)'(off) + (NB_W+1)'(nbytes);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    localparam logic [NB_W:0] LANE_IDX = (NB_W+1)'(g);
    assign be[g] = (LANE_IDX >= lo_lane) && (LANE_IDX < hi_lane);
  end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int unsigned CNT_W = sg_dma_pkg::CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                to_mem,
  input  logic [31:0]         tbl_base_lo,
  input  logic [31:0]         tbl_base_hi,
  input  logic [31:0]         buf_upper,
  input  logic                irq_clr,
  input  logic                err_clr,
  output logic                active,
  output logic                irq_flag,
  output logic                err_flag,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic [BE_W-1:0]     mem_be,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                dev_tx_valid,
  output logic [WORD_W-1:0]   dev_tx_data,
  output logic [BE_W-1:0]     dev_tx_be,
  input  logic                dev_tx_ready,
  input  logic                dev_rx_valid,
  input  logic [WORD_W-1:0]   dev_rx_data,
  output logic                dev_rx_ready
);
  localparam int unsigned HALF_W = ADDR_W / 2;
  localparam int unsigned OFF_W  = $clog2(BE_W);
  localparam int unsigned NB_W   = OFF_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sg_state_e          state_q, state_d;
  logic               start_q;
  logic               dir_q, dir_d;
  logic [HALF_W-1:0]  tblhi_q, tblhi_d, bufhi_q, bufhi_d;
  logic [HALF_W-1:0]  ptr_q, ptr_d, cur_q, cur_d, lo_q, lo_d;
  logic [CNT_W:0]     rem_q, rem_d;
  logic               eot_q, eot_d;
  logic [WORD_W-1:0]  hold_q, hold_d;
  logic [BE_W-1:0]    hbe_q, hbe_d;
  logic               irq_q, irq_d, err_q, err_d;

  logic [HALF_W-1:0]  dec_addr;
  logic [CNT_W:0]     dec_cnt;
  logic               dec_last, dec_cross;
  logic [BE_W-1:0]    lane_be;
  logic [NB_W-1:0]    lane_n;
  logic               start_rise;

  sg_desc_decode #(.CNT_W(CNT_W), .AW(HALF_W)) i_decode (
    .word0    (lo_q),
    .word1    (mem_rdata),
    .buf_addr (dec_addr),
    .byte_cnt (dec_cnt),
    .last     (dec_last),
    .cross_err(dec_cross)
  );

  sg_beat_lanes #(.BE_W(BE_W), .CNT_W(CNT_W)) i_lanes (
    .off      (cur_q[OFF_W-1:0]),
    .remaining(rem_q),
    .be       (lane_be),
    .nbytes   (lane_n)
  );

  assign start_rise = start & ~start_q;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    tblhi_d = tblhi_q;
    bufhi_d = bufhi_q;
    ptr_d   = ptr_q;
    cur_d   = cur_q;
    lo_d    = lo_q;
    rem_d   = rem_q;
    eot_d   = eot_q;
    hold_d  = hold_q;
    hbe_d   = hbe_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_rise) begin
          state_d = S_FETCH_LO;
          ptr_d   = tbl_base_lo & ~HALF_W'(3);
          dir_d   = to_mem;
          tblhi_d = tbl_base_hi;
          bufhi_d = buf_upper;
        end
      end
      S_FETCH_LO: begin
        if (mem_ack) begin
          lo_d    = mem_rdata;
          state_d = start ? S_FETCH_HI : S_IDLE;
        end
      end
      S_FETCH_HI: begin
        if (mem_ack) begin
          if (!start) begin
            state_d = S_IDLE;
          end else if (dec_cross) begin
            state_d = S_ERROR;
          end else begin
            cur_d   = dec_addr;
            rem_d   = dec_cnt;
            eot_d   = dec_last;
            state_d = dir_q ? S_DEV : S_MEM;
          end
        end
      end
      S_MEM: begin
        if (mem_ack) begin
          cur_d = cur_q + HALF_W'(lane_n);
          rem_d = rem_q - (CNT_W+1)'(lane_n);
          if (!dir_q) begin
            hold_d = mem_rdata;
            hbe_d  = lane_be;
          end
          if (!start) begin
            state_d = S_IDLE;
          end else if (dir_q) begin
            state_d = (rem_d == '0) ? S_NEXT : S_DEV;
          end else begin
            state_d = S_DEV;
          end
        end
      end
      S_DEV: begin
        if (!start) begin
          state_d = S_IDLE;
        end else if (dir_q) begin
          if (dev_rx_valid) begin
            hold_d  = dev_rx_data;
            state_d = S_MEM;
          end
        end else if (dev_tx_ready) begin
          state_d = (rem_q == '0) ? S_NEXT : S_MEM;
        end
      end
      S_NEXT: begin
        if (!start) begin
          state_d = S_IDLE;
        end else if (eot_q) begin
          state_d = S_DONE;
        end else begin
          ptr_d   = ptr_q + HALF_W'(DESC_LEN);
          state_d = S_FETCH_LO;
        end
      end
      S_DONE:  state_d = S_IDLE;
      S_ERROR: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign irq_d = (irq_q & ~irq_clr) | (state_q == S_DONE);
  assign err_d = (err_q & ~err_clr) | (state_q == S_ERROR);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= S_IDLE;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      tblhi_q <= '0;
      bufhi_q <= '0;
      ptr_q   <= '0;
      cur_q   <= '0;
      lo_q    <= '0;
      rem_q   <= '0;
      eot_q   <= 1'b0;
      hold_q  <= '0;
      hbe_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start;
      dir_q   <= dir_d;
      tblhi_q <= tblhi_d;
      bufhi_q <= bufhi_d;
      ptr_q   <= ptr_d;
      cur_q   <= cur_d;
      lo_q    <= lo_d;
      rem_q   <= rem_d;
      eot_q   <= eot_d;
      hold_q  <= hold_d;
      hbe_q   <= hbe_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    mem_be   = '1;
    unique case (state_q)
      S_FETCH_LO: begin
        mem_req  = 1'b1;
        mem_addr = {tblhi_q, ptr_q};
      end
      S_FETCH_HI: begin
        mem_req  = 1'b1;
        mem_addr = {tblhi_q, ptr_q + HALF_W'(4)};
      end
      S_MEM: begin
        mem_req  = 1'b1;
        mem_we   = dir_q;
        mem_addr = {bufhi_q, cur_q[HALF_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_be   = lane_be;
      end
      default: ;
    endcase
  end

  assign mem_wdata    = hold_q;
  assign dev_tx_valid = (state_q == S_DEV) && !dir_q && start;
  assign dev_tx_data  = hold_q;
  assign dev_tx_be    = hbe_q;
  assign dev_rx_ready = (state_q == S_DEV) && dir_q && start;
  assign active       = (state_q != S_IDLE);
  assign irq_flag     = irq_q;
  assign err_flag     = err_q;

  // R12: request held until accepted
  a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R12: never an empty beat
  a_r12_be_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_req |-> mem_be != '0);
  // R4: word-aligned requests
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);
  // R10: no fresh request once stopped
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !start && !mem_req |=> !mem_req);
  // R11: sticky flags
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_flag && !irq_clr |=> irq_flag);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_sync_q)
    err_flag && !err_clr |=> err_flag);
  // R5/R6: device sides never both open
  a_r5_one_side: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(dev_tx_valid && dev_rx_ready));
  // R8: completion ends activity
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(irq_flag) |-> !active);
endmodule

// File: tb/test_sg_dma_engine.sv
module test_sg_dma_engine;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  typedef struct {
    logic [63:0] addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] data;
    string       tag;
  } mem_op_t;

  typedef struct {
    logic [31:0] data;
    logic [3:0]  be;
  } beat_t;

  logic clk, rst_n, start, to_mem, irq_clr, err_clr;
  logic [31:0] tbl_base_lo, tbl_base_hi, buf_upper;
  logic active, irq_flag, err_flag, mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, dev_tx_data, dev_rx_data;
  logic [3:0]  mem_be, dev_tx_be;
  logic dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready;

  sg_dma_engine i_sg_dma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
    .tbl_base_lo(tbl_base_lo), .tbl_base_hi(tbl_base_hi), .buf_upper(buf_upper),
    .irq_clr(irq_clr), .err_clr(err_clr),
    .active(active), .irq_flag(irq_flag), .err_flag(err_flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_be(dev_tx_be),
    .dev_tx_ready(dev_tx_ready), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_ready(dev_rx_ready)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  bit tx_alt = 0;
  bit rx_alt = 0;
  int rx_seq = 0;

  logic [31:0] mem_arr [logic [63:0]];
  mem_op_t     exp_mem[$];
  beat_t       exp_tx[$];
  logic [31:0] rx_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [63:0] a);
    if (mem_arr.exists(a)) return mem_arr[a];
    return a[31:0] ^ 32'h5A5A_0F0F;
  endfunction

  // memory responder: decides on the negative edge, handshake completes at the next rising edge
  always @(negedge clk) begin
    mem_op_t e;
    if (rst_n && mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ack  = 1'b1;
        wait_cnt = 0;
        if (exp_mem.size() == 0) begin
          chk(1'b0, "R10", "unexpected memory request", mem_addr, 64'h0);
        end else begin
          e = exp_mem.pop_front();
          chk(mem_addr == e.addr, e.tag, "request address", mem_addr, e.addr);
          chk(mem_we == e.we, e.tag, "request direction", 64'(mem_we), 64'(e.we));
          chk(mem_be == e.be, (e.tag == "R2") ? "R12" : "R4", "byte enables",
              64'(mem_be), 64'(e.be));
          if (e.we) chk(mem_wdata == e.data, "R6", "write data", 64'(mem_wdata), 64'(e.data));
        end
        if (mem_we) begin
          mem_arr[mem_addr] = mem_wdata;
        end else begin
          mem_rdata = rd(mem_addr);
          if (e.tag == "R5") exp_tx.push_back('{data: mem_rdata, be: mem_be});
        end
      end else begin
        mem_ack  = 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  // device side responders
  always @(negedge clk) begin
    beat_t b;
    dev_tx_ready = tx_alt ? cyc[0] : 1'b1;
    if (rst_n && dev_tx_valid && dev_tx_ready) begin
      if (exp_tx.size() == 0) begin
        chk(1'b0, "R5", "unexpected device beat", 64'(dev_tx_data), 64'h0);
      end else begin
        b = exp_tx.pop_front();
        chk(dev_tx_data == b.data, "R5", "device beat data", 64'(dev_tx_data), 64'(b.data));
        chk(dev_tx_be == b.be, "R5", "device beat enables", 64'(dev_tx_be), 64'(b.be));
      end
    end
    dev_rx_valid = 1'b0;
    if (rst_n && dev_rx_ready && rx_q.size() > 0 && (!rx_alt || cyc[0])) begin
      dev_rx_valid = 1'b1;
      dev_rx_data  = rx_q.pop_front();
    end
  end

  // behavioural reference: walks the table held in bench memory
  task automatic plan(input logic [31:0] tlo, input logic [31:0] thi,
                      input logic [31:0] bhi, input bit dir, output bit exp_err);
    logic [31:0] ptr, w0, w1;
    logic [63:0] a0;
    int base, cnt, a, left, off, n;
    exp_err = 0;
    ptr = {tlo[31:2], 2'b00};
    forever begin
      a0 = {thi, ptr};
      exp_mem.push_back('{addr: a0, we: 1'b0, be: 4'hF, data: 32'h0, tag: "R2"});
      w0 = rd(a0);
      exp_mem.push_back('{addr: a0 + 64'd4, we: 1'b0, be: 4'hF, data: 32'h0, tag: "R2"});
      w1 = rd(a0 + 64'd4);
      base = int'(w0 & 32'hFFFF_FFFE);
      cnt  = (w1[15:0] == 16'h0) ? 65536 : int'(w1[15:0]);
      if ((base & 32'hFFFF) + cnt > 65536) begin
        exp_err = 1;
        return;
      end
      a = base;
      left = cnt;
      while (left > 0) begin
        off = a & 3;
        n = (4 - off < left) ? 4 - off : left;
        if (dir) begin
          rx_q.push_back(32'hC0DE_0000 + 32'(rx_seq));
          exp_mem.push_back('{addr: {bhi, 32'(a) & 32'hFFFF_FFFC}, we: 1'b1,
                              be: 4'(((1 << n) - 1) << off),
                              data: 32'hC0DE_0000 + 32'(rx_seq), tag: "R6"});
          rx_seq = rx_seq + 1;
        end else begin
          exp_mem.push_back('{addr: {bhi, 32'(a) & 32'hFFFF_FFFC}, we: 1'b0,
                              be: 4'(((1 << n) - 1) << off), data: 32'h0, tag: "R5"});
        end
        a = a + n;
        left = left - n;
      end
      if (w1[31]) return;
      ptr = ptr + 32'd8;
    end
  endtask

  task automatic put_desc(input logic [63:0] at, input logic [31:0] w0, input logic [31:0] w1);
    mem_arr[at] = w0;
    mem_arr[at + 64'd4] = w1;
  endtask

  task automatic clear_flags();
    @(posedge clk); #2;
    irq_clr = 1'b1; err_clr = 1'b1;
    @(posedge clk); #2;
    irq_clr = 1'b0; err_clr = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int n = 0;
    do begin @(negedge clk); n++; end while (!active && n < 10);
    while (active && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic run(input logic [31:0] tlo, input logic [31:0] thi, input logic [31:0] bhi,
                     input bit dir, input string tag);
    bit exp_err;
    plan(tlo, thi, bhi, dir, exp_err);
    @(posedge clk); #2;
    tbl_base_lo = tlo; tbl_base_hi = thi; buf_upper = bhi; to_mem = dir; start = 1'b1;
    wait_idle(150000);
    chk(!active, tag, "active after table", 64'(active), 64'h0);
    chk(irq_flag == !exp_err, exp_err ? "R9" : "R8", "irq_flag as active falls",
        64'(irq_flag), 64'(!exp_err));
    chk(err_flag == exp_err, "R9", "err_flag", 64'(err_flag), 64'(exp_err));
    chk(exp_mem.size() == 0, tag, "memory ops left", 64'(exp_mem.size()), 64'h0);
    chk(exp_tx.size() == 0, "R5", "device beats left", 64'(exp_tx.size()), 64'h0);
    chk(rx_q.size() == 0, "R6", "device words left", 64'(rx_q.size()), 64'h0);
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  initial begin
    bit dummy;
    int req_seen;
    rst_n = 1'b0; start = 1'b0; to_mem = 1'b0; irq_clr = 1'b0; err_clr = 1'b0;
    tbl_base_lo = '0; tbl_base_hi = '0; buf_upper = '0;
    mem_ack = 1'b0; mem_rdata = '0; dev_tx_ready = 1'b0;
    dev_rx_valid = 1'b0; dev_rx_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!active && !irq_flag && !err_flag, "R1", "status in reset",
        {61'h0, active, irq_flag, err_flag}, 64'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!mem_req && !dev_tx_valid && !dev_rx_ready, "R1", "handshakes after reset",
        {61'h0, mem_req, dev_tx_valid, dev_rx_ready}, 64'h0);
    chk(!active && !irq_flag && !err_flag, "R1", "status after reset",
        {61'h0, active, irq_flag, err_flag}, 64'h0);

    // R2 R3 R4 R5 R7: memory to device, halfword start, ignored low bits
    put_desc({32'h2, 32'h1000}, 32'h0002_0006, 32'h0000_0007);
    put_desc({32'h2, 32'h1008}, 32'h0003_0001, 32'h8000_000C);
    mem_lat = 1; tx_alt = 1;
    run(32'h0000_1003, 32'h2, 32'h7, 1'b0, "R3");

    // R11: irq stays until cleared
    repeat (3) @(negedge clk);
    chk(irq_flag, "R11", "irq_flag holds", 64'(irq_flag), 64'h1);
    @(posedge clk); #2; irq_clr = 1'b1;
    @(posedge clk); #2; irq_clr = 1'b0;
    @(negedge clk);
    chk(!irq_flag, "R11", "irq_flag cleared", 64'(irq_flag), 64'h0);

    // R6 R8: device to memory, three descriptors, last ends exactly on region edge
    put_desc({32'h0, 32'h2000}, 32'h0004_0000, 32'h0000_0005);
    put_desc({32'h0, 32'h2008}, 32'h0004_0102, 32'h0000_0002);
    put_desc({32'h0, 32'h2010}, 32'h0004_FFFC, 32'h8000_0004);
    mem_lat = 0; tx_alt = 0; rx_alt = 1;
    run(32'h0000_2000, 32'h0, 32'h1, 1'b1, "R6");
    chk(mem_arr[{32'h1, 32'h0004_FFFC}] == 32'hC0DE_0000 + 32'(rx_seq - 1), "R6",
        "last word in memory", 64'(mem_arr[{32'h1, 32'h0004_FFFC}]),
        64'(32'hC0DE_0000 + 32'(rx_seq - 1)));
    clear_flags();

    // R3: zero count moves a full 64 KB
    put_desc({32'h0, 32'h3000}, 32'h0005_0000, 32'h8000_0000);
    rx_alt = 0;
    run(32'h0000_3000, 32'h0, 32'h3, 1'b0, "R3");
    clear_flags();

    // R9: second buffer crosses a region edge
    put_desc({32'h0, 32'h4000}, 32'h0006_0000, 32'h0000_0004);
    put_desc({32'h0, 32'h4008}, 32'h0006_FFFE, 32'h8000_0004);
    run(32'h0000_4000, 32'h0, 32'h4, 1'b1, "R9");
    @(posedge clk); #2; err_clr = 1'b1;
    @(posedge clk); #2; err_clr = 1'b0;
    @(negedge clk);
    chk(!err_flag, "R11", "err_flag cleared", 64'(err_flag), 64'h0);

    // R10: lowering start mid-table
    put_desc({32'h0, 32'h5000}, 32'h0007_0000, 32'h8000_1000);
    mem_lat = 1;
    plan(32'h0000_5000, 32'h0, 32'h5, 1'b0, dummy);
    @(posedge clk); #2;
    tbl_base_lo = 32'h5000; tbl_base_hi = 32'h0; buf_upper = 32'h5; to_mem = 1'b0;
    start = 1'b1;
    repeat (40) @(posedge clk);
    #2; start = 1'b0;
    repeat (6) @(negedge clk);
    chk(!active, "R10", "idle after stop", 64'(active), 64'h0);
    req_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) req_seen++;
    end
    chk(req_seen == 0, "R10", "requests after stop", 64'(req_seen), 64'h0);
    chk(!irq_flag && !err_flag, "R10", "flags after stop", {62'h0, irq_flag, err_flag}, 64'h0);
    chk(exp_mem.size() > 0, "R10", "table left unfinished", 64'(exp_mem.size()), 64'h1);
    exp_mem.delete();
    exp_tx.delete();

    finish_run();
  end
endmodule